// File: doc/BRIEF.md
# Result Most-Significant-Word Locator

When a big-number arithmetic operation finishes, this block reads the result from word-addressed operand RAM and finds its most significant nonzero 32-bit word. The least significant word of a vector sits at its base address. The block reads downward from the top word, one word per cycle, and stops at the first word that is not zero. It reports that word's address, or a dedicated flag when every word of the vector is zero. After a divide or modulo, the block runs the same scan on the remainder vector and reports it in a second status word. On request, it can instead place the bit index of the highest set bit of the result's top word in the second status word.

A single `start_i` pulse launches the scan and carries the base pointers, the lengths and the mode bits. The RAM port has no handshake. The block drives `rd_en_o` and `rd_addr_o`, and the RAM must return the addressed word on `rd_data_i` in the next cycle. The block never stalls a request. The RAM side cannot apply back-pressure and must always answer with exactly one cycle of latency. The status words change only in the cycle when `done_o` pulses. At all other times they hold their previous values.

Top module: `msw_locator`

## Requirements
- R1: For a result vector that has a nonzero word, `res_status_o[10:0]` is the address of the highest-addressed nonzero word, `res_status_o[15]` is 0, and bits [14:11] are 0.
- R2: For a result vector whose words are all zero, including a length of 0, `res_status_o` has bit 15 set and bits [10:0] equal to the result base pointer.
- R3: When `divmod_i` is 1, `rem_status_o` reports the remainder vector using the layout of R1 and R2, with the remainder base pointer.
- R4: When `ms_one_i` is 1 and `divmod_i` is 0, `rem_status_o[4:0]` is the index of the highest set bit in the result's top nonzero word, and the other bits are 0. If the result is zero, `rem_status_o` is 16'h8000.
- R5: When `divmod_i` is 1, `ms_one_i` has no effect, and `rem_status_o` follows R3.
- R6: When `divmod_i` and `ms_one_i` are both 0, `rem_status_o` keeps its previous value.
- R7: `done_o` is a pulse of one cycle. Both status words change only in that cycle. A `start_i` that arrives while `busy_o` is high is ignored.
- R8: For each vector, reads start at base+len-1 and step down by one address per cycle. They never leave the range [base, base+len-1] and stop after the first nonzero word. A vector issues len-k reads when its top nonzero word is at offset k, and len reads when it is all zero.
- R9: After reset, both status words are 0, and `done_o`, `busy_o` and `rd_en_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch a scan (ignored while busy) |
| divmod_i | input | 1 | The operation was a divide or modulo; scan the remainder too |
| ms_one_i | input | 1 | Report the leading-one index in `rem_status_o` |
| res_base_i | input | 11 | Word address of the result's least significant word |
| res_len_i | input | 9 | Result length in words |
| rem_base_i | input | 11 | Word address of the remainder's least significant word |
| rem_len_i | input | 9 | Remainder length in words |
| rd_en_o | output | 1 | RAM read strobe |
| rd_addr_o | output | 11 | RAM read address |
| rd_data_i | input | 32 | RAM read data, valid one cycle after `rd_en_o` |
| busy_o | output | 1 | A scan is in progress |
| done_o | output | 1 | Single-cycle completion pulse |
| res_status_o | output | 16 | Result status: bit 15 zero flag, [10:0] word address |
| rem_status_o | output | 16 | Remainder status or leading-one index |

## Verification
The assertions check every cycle that reads step down by exactly one address and stay inside the vector window. They also check that the status words hold between done pulses, that done lasts one cycle and arrives only with the block idle, and that a zero result points at its base. Only the bench scenarios can show that the reported address is the correct word, that the leading-one index matches the data, and that the mode combinations select the right content for the second status word. The same holds for exact read counts and for a start pulse that arrives mid-scan being dropped.

// File: rtl/msw_pkg.sv
package msw_pkg;
  localparam int DEF_ADDR_W = 11;
  localparam int DEF_LEN_W  = 9;
  localparam int DEF_WORD_W = 32;
  localparam int DEF_ST_W   = 16;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RES  = 2'd1,
    PH_REM  = 2'd2
  } phase_t;
endpackage

// File: rtl/msw_lead_one.sv
module msw_lead_one #(
  parameter int WORD_W = msw_pkg::DEF_WORD_W,
  localparam int IDX_W = $clog2(WORD_W)
) (
  input  logic [WORD_W-1:0] word_i,
  output logic [IDX_W-1:0]  idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < WORD_W; i++) begin
      if (word_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/msw_scan_unit.sv
module msw_scan_unit #(
  parameter int ADDR_W = msw_pkg::DEF_ADDR_W,
  parameter int LEN_W  = msw_pkg::DEF_LEN_W,
  parameter int WORD_W = msw_pkg::DEF_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic              done_o,
  output logic              zero_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [WORD_W-1:0] word_o
);
  logic              busy_q, pend_q;
  logic [LEN_W-1:0]  left_q, len_q;
  logic [ADDR_W-1:0] next_q, pend_addr_q, base_q;
  logic              data_nz, hit, empty, issue, finish;

  assign data_nz = |rd_data_i;
  assign hit     = busy_q && pend_q && data_nz;
  assign empty   = busy_q && (left_q == '0) && !(pend_q && data_nz);
  assign issue   = busy_q && !hit && (left_q != '0);
  assign finish  = hit || empty;

  assign rd_en_o   = issue;
  assign rd_addr_o = next_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      pend_q      <= 1'b0;
      left_q      <= '0;
      len_q       <= '0;
      next_q      <= '0;
      pend_addr_q <= '0;
      base_q      <= '0;
      done_o      <= 1'b0;
      zero_o      <= 1'b0;
      addr_o      <= '0;
      word_o      <= '0;
    end else begin
      done_o <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          pend_q <= 1'b0;
          base_q <= base_i;
          len_q  <= len_i;
          left_q <= len_i;
          next_q <= base_i + ADDR_W'(len_i) - ADDR_W'(1);
        end
      end else begin
        pend_q <= issue;
        if (issue) begin
          left_q      <= left_q - LEN_W'(1);
          next_q      <= next_q - ADDR_W'(1);
          pend_addr_q <= next_q;
        end
        if (finish) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
          zero_o <= !hit;
          addr_o <= hit ? pend_addr_q : base_q;
          word_o <= hit ? rd_data_i : '0;
        end
      end
    end
  end

  AST_RD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |-> ((rd_addr_o - base_q) < ADDR_W'(len_q))) else $error("read outside vector"); // R8
  AST_RD_DESCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_o && $past(rd_en_o)) |-> (rd_addr_o == $past(rd_addr_o) - ADDR_W'(1))) else $error("read not descending"); // R8
endmodule

// File: rtl/msw_locator.sv
module msw_locator #(
  parameter int ADDR_W = msw_pkg::DEF_ADDR_W,
  parameter int LEN_W  = msw_pkg::DEF_LEN_W,
  parameter int WORD_W = msw_pkg::DEF_WORD_W,
  parameter int ST_W   = msw_pkg::DEF_ST_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              divmod_i,
  input  logic              ms_one_i,
  input  logic [ADDR_W-1:0] res_base_i,
  input  logic [LEN_W-1:0]  res_len_i,
  input  logic [ADDR_W-1:0] rem_base_i,
  input  logic [LEN_W-1:0]  rem_len_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ST_W-1:0]   res_status_o,
  output logic [ST_W-1:0]   rem_status_o
);
  import msw_pkg::*;
  localparam int IDX_W = $clog2(WORD_W);
  localparam int PAD_W = ST_W - 1 - ADDR_W;
  localparam logic [ST_W-1:0] ZERO_FLAG = ST_W'(1) << (ST_W - 1);

  phase_t            phase_q;
  logic              divmod_q, msone_q;
  logic [ADDR_W-1:0] rem_base_q, res_base_q;
  logic [LEN_W-1:0]  rem_len_q;
  logic              res_zero_q;
  logic [ADDR_W-1:0] res_addr_q;

  logic              sc_start, sc_done, sc_zero;
  logic [ADDR_W-1:0] sc_base, sc_addr;
  logic [LEN_W-1:0]  sc_len;
  logic [WORD_W-1:0] sc_word;
  logic [IDX_W-1:0]  lead_idx;
  logic              fin_res, fin_rem, go_rem;

  function automatic logic [ST_W-1:0] pack(input logic z, input logic [ADDR_W-1:0] a);
    return {z, {PAD_W{1'b0}}, a};
  endfunction

  assign busy_o   = (phase_q != PH_IDLE);
  assign go_rem   = (phase_q == PH_RES) && sc_done && divmod_q;
  assign fin_res  = (phase_q == PH_RES) && sc_done && !divmod_q;
  assign fin_rem  = (phase_q == PH_REM) && sc_done;
  assign sc_start = ((phase_q == PH_IDLE) && start_i) || go_rem;
  assign sc_base  = (phase_q == PH_IDLE) ? res_base_i : rem_base_q;
  assign sc_len   = (phase_q == PH_IDLE) ? res_len_i  : rem_len_q;

  msw_scan_unit #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .WORD_W(WORD_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .start_i(sc_start), .base_i(sc_base), .len_i(sc_len),
    .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
    .done_o(sc_done), .zero_o(sc_zero), .addr_o(sc_addr), .word_o(sc_word)
  );

  msw_lead_one #(.WORD_W(WORD_W)) u_lead (.word_i(sc_word), .idx_o(lead_idx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q      <= PH_IDLE;
      divmod_q     <= 1'b0;
      msone_q      <= 1'b0;
      rem_base_q   <= '0;
      rem_len_q    <= '0;
      res_base_q   <= '0;
      res_zero_q   <= 1'b0;
      res_addr_q   <= '0;
      done_o       <= 1'b0;
      res_status_o <= '0;
      rem_status_o <= '0;
    end else begin
      done_o <= 1'b0;
      case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q    <= PH_RES;
          divmod_q   <= divmod_i;
          msone_q    <= ms_one_i;
          rem_base_q <= rem_base_i;
          rem_len_q  <= rem_len_i;
          res_base_q <= res_base_i;
        end
        PH_RES: if (sc_done) begin
          if (divmod_q) begin
            phase_q    <= PH_REM;
            res_zero_q <= sc_zero;
            res_addr_q <= sc_addr;
          end else begin
            phase_q      <= PH_IDLE;
            done_o       <= 1'b1;
            res_status_o <= pack(sc_zero, sc_addr);
            if (msone_q)
              rem_status_o <= sc_zero ? ZERO_FLAG : ST_W'(lead_idx);
          end
        end
        PH_REM: if (sc_done) begin
          phase_q      <= PH_IDLE;
          done_o       <= 1'b1;
          res_status_o <= pack(res_zero_q, res_addr_q);
          rem_status_o <= pack(sc_zero, sc_addr);
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o) else $error("done longer than one cycle"); // R7
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(res_status_o) && $stable(rem_status_o))) else $error("status moved without done"); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o) else $error("done while busy"); // R7
  AST_ZERO_AT_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && res_status_o[ST_W-1]) |-> (res_status_o[ADDR_W-1:0] == res_base_q)) else $error("zero result not at base"); // R2
  AST_MSONE_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && msone_q && !divmod_q && !res_status_o[ST_W-1]) |-> (rem_status_o[ST_W-1:IDX_W] == '0)) else $error("ms-one field overflow"); // R4
endmodule

// File: tb/msw_locator_bench.sv
module msw_locator_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCASE = 7;
  localparam int T_BASE [NCASE] = '{16, 40, 100, 200, 600, 500, 700};
  localparam int T_LEN  [NCASE] = '{4, 8, 6, 5, 5, 1, 3};
  localparam int T_POS  [NCASE] = '{3, 2, -1, 0, 4, 0, 1};
  localparam int T_VAL  [NCASE] = '{32'h8000_0000, 32'h0001_0000, 0, 1, 32'h0000_0100, 5, 32'h0000_0001};
  localparam int T_RBASE[NCASE] = '{0, 0, 0, 300, 400, 0, 0};
  localparam int T_RLEN [NCASE] = '{0, 0, 0, 3, 4, 0, 0};
  localparam int T_RPOS [NCASE] = '{-1, -1, -1, 2, -1, -1, -1};
  localparam int T_RVAL [NCASE] = '{0, 0, 0, 7, 0, 0, 0};
  localparam bit T_DM   [NCASE] = '{0, 0, 0, 1, 1, 0, 0};
  localparam bit T_MO   [NCASE] = '{0, 1, 1, 1, 0, 0, 1};

  logic clk = 0, rst_n = 0;
  logic start_i = 0, divmod_i = 0, ms_one_i = 0;
  logic [10:0] res_base_i = '0, rem_base_i = '0;
  logic [8:0]  res_len_i = '0, rem_len_i = '0;
  logic rd_en_o, busy_o, done_o;
  logic [10:0] rd_addr_o;
  logic [31:0] rd_data_i;
  logic [15:0] res_status_o, rem_status_o;
  logic [31:0] mem [2048];
  int checks = 0, errors = 0, rd_cnt = 0;
  logic [15:0] last_rem = '0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msw_locator u_msw_locator (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .divmod_i(divmod_i), .ms_one_i(ms_one_i),
    .res_base_i(res_base_i), .res_len_i(res_len_i), .rem_base_i(rem_base_i), .rem_len_i(rem_len_i),
    .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
    .busy_o(busy_o), .done_o(done_o), .res_status_o(res_status_o), .rem_status_o(rem_status_o)
  );

  always_ff @(posedge clk) if (rd_en_o) rd_data_i <= mem[rd_addr_o];
  always @(posedge clk) if (rd_en_o) rd_cnt = rd_cnt + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int msb(input logic [31:0] v);
    int r = 0;
    for (int i = 0; i < 32; i++) if (v[i]) r = i;
    return r;
  endfunction

  task automatic fill(input int base, input int pos, input int val);
    if (pos >= 0) begin
      mem[base + pos] = val;
      if (pos > 0) mem[base] = 32'h1;
    end
  endtask

  task automatic launch(input int b, input int l, input int rb, input int rl, input bit dm, input bit mo);
    @(negedge clk);
    res_base_i = 11'(b); res_len_i = 9'(l); rem_base_i = 11'(rb); rem_len_i = 9'(rl);
    divmod_i = dm; ms_one_i = mo; start_i = 1;
    @(negedge clk);
    start_i = 0;
  endtask

  task automatic wait_done();
    while (!done_o) @(negedge clk);
  endtask

  task automatic run_case(input int b, input int l, input int p, input int v,
                          input int rb, input int rl, input int rp, input int rv,
                          input bit dm, input bit mo);
    logic [15:0] er, em;
    int exp_rd;
    string rl_tag;
    for (int i = 0; i < 2048; i++) mem[i] = '0;
    fill(b, p, v);
    if (dm) fill(rb, rp, rv);
    rd_cnt = 0;
    er = (p < 0) ? (16'h8000 | 16'(b)) : 16'(b + p);
    exp_rd = (p < 0) ? l : l - p;
    if (dm) begin
      em = (rp < 0) ? (16'h8000 | 16'(rb)) : 16'(rb + rp);
      exp_rd += (rp < 0) ? rl : rl - rp;
      rl_tag = mo ? "R5" : "R3";
    end else if (mo) begin
      em = (p < 0) ? 16'h8000 : 16'(msb(v));
      rl_tag = "R4";
    end else begin
      em = last_rem;
      rl_tag = "R6";
    end
    launch(b, l, rb, rl, dm, mo);
    chk(res_status_o == 16'h0 || !done_o, "R7", {16'h0, res_status_o}, 32'h0);
    wait_done();
    chk(res_status_o == er, (p < 0) ? "R2" : "R1", {16'h0, res_status_o}, {16'h0, er});
    chk(rem_status_o == em, rl_tag, {16'h0, rem_status_o}, {16'h0, em});
    chk(rd_cnt == exp_rd, "R8", rd_cnt, exp_rd);
    last_rem = em;
    @(negedge clk);
    chk(done_o == 1'b0, "R7", {31'h0, done_o}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] hold_res, hold_rem;
    for (int i = 0; i < 2048; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(res_status_o == 0 && rem_status_o == 0, "R9", {res_status_o, rem_status_o}, 32'h0);
    chk(!done_o && !busy_o && !rd_en_o, "R9", {29'h0, done_o, busy_o, rd_en_o}, 32'h0);
    rst_n = 1;
    @(negedge clk);

    for (int c = 0; c < NCASE; c++)
      run_case(T_BASE[c], T_LEN[c], T_POS[c], T_VAL[c], T_RBASE[c], T_RLEN[c],
               T_RPOS[c], T_RVAL[c], T_DM[c], T_MO[c]);

    // R2: zero length gives zero flag and base address with no reads
    run_case(900, 0, -1, 0, 0, 0, -1, 0, 0, 0);

    // R7: start while busy is ignored, status holds during the scan
    for (int i = 0; i < 2048; i++) mem[i] = '0;
    fill(1000, 9, 32'h44);
    hold_res = res_status_o; hold_rem = rem_status_o;
    launch(1000, 12, 0, 0, 0, 0);
    chk(busy_o == 1'b1, "R7", {31'h0, busy_o}, 32'h1);
    @(negedge clk);
    res_base_i = 11'd50; res_len_i = 9'd2; start_i = 1;
    @(negedge clk);
    start_i = 0;
    chk(res_status_o == hold_res && rem_status_o == hold_rem, "R7",
        {res_status_o, rem_status_o}, {hold_res, hold_rem});
    wait_done();
    chk(res_status_o == 16'(1009), "R7", {16'h0, res_status_o}, 32'd1009);
    chk(rem_status_o == hold_rem, "R6", {16'h0, rem_status_o}, {16'h0, hold_rem});
    @(negedge clk);
    chk(!busy_o && !done_o, "R7", {30'h0, busy_o, done_o}, 32'h0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule